// File: doc/BRIEF.md
# Four-Level Virtual Address Page Walker

This block walks a four-level 64-bit page table to translate a 48-bit virtual address into a physical address. A walk is launched with a single-cycle `start` pulse carrying the virtual address, the root register value, the access kind (load or store) and whether the no-execute feature is enabled. The walker fetches one 64-bit entry per level through a memory port that accepts one read or one 32-bit compare-and-swap at a time. It stops at a 1 GB, 2 MB or 4 KB leaf.

While it descends, the walker sets the accessed bit of every entry it passes through and the dirty bit of the leaf on a store. Both updates are made with compare-and-swap operations. A lost race on an upper level re-reads that level. A lost race on the leaf restarts the walk from the root. The walker folds the user, writable and no-execute bits of all levels into one attribute set.

A `done` pulse ends each walk. The translated address, page size, attributes and a fault class stay on the outputs until the next walk finishes. A later permission and error-code stage reads these outputs.

Top module: `vmap_walker`

## Requirements
- R1: The table base is the root value with bits 11:0 cleared. Each level reads the 64-bit entry at base + 8 × index. The index is virtual-address bits 47:39, 38:30, 29:21 and 20:12 for levels 0 to 3. A non-leaf entry supplies the next base in bits PA_W-1:12.
- R2: An entry with bit 0 (present) clear ends the walk with `ok`=0 and `fault`=1 (not present). No further entry is read.
- R3: An entry ends the walk with `fault`=2 (reserved) in any of these cases: it sets any bit from PA_W to 51; it sets bit 63 while `nx_en`=0; it sets bit 7 (page size) at level 0.
- R4: Bit 7 set at level 1 gives a 1 GB leaf (`page_size`=2), and at level 2 a 2 MB leaf (`page_size`=1). Level 3 is always a 4 KB leaf (`page_size`=0). `pa` is the leaf frame with the bits below the page size replaced by the matching virtual-address bits.
- R5: In a 1 GB or 2 MB leaf, any frame bit from 13 up to the page-size boundary ends the walk with `fault`=2. Bit 12 is exempt.
- R6: A non-leaf entry whose bit 5 (accessed) is clear is updated by a compare-and-swap on its low word. The compare value is the low word as read, and the swap value is that word with bit 5 set. No swap is issued when the bit is already set. A failed compare re-reads the same level.
- R7: At the leaf, bit 5 is set, and on a store bit 6 (dirty) is set too, in one compare-and-swap, skipped when already set. A failed compare restarts the walk from the root table.
- R8: `attr_user` is the AND of bit 2 over the levels walked. `attr_write` is the AND of bit 1. `attr_nx` is the OR of bit 63.
- R9: On a load whose leaf has bit 6 clear, `attr_write` is 0 whatever the entry bits grant.
- R10: A virtual address whose bits 63:47 are not all equal ends the walk with `fault`=3 (non-canonical) and no memory request.
- R11: Only one memory request is outstanding. A request holds its fields until `req_ready`. `done` is a single-cycle pulse, and the results hold until the next walk completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken when idle) |
| va | input | 64 | Virtual address |
| root | input | 64 | Root table register |
| is_store | input | 1 | Access is a store |
| nx_en | input | 1 | No-execute feature enabled |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory request accepted |
| req_addr | output | PA_W | Entry address |
| req_cas | output | 1 | 1: compare-and-swap, 0: read |
| req_cmp | output | 32 | Compare value for the low word |
| req_swap | output | 32 | Swap value for the low word |
| rsp_valid | input | 1 | Response valid |
| rsp_data | input | 64 | Entry read, or old value for a swap |
| done | output | 1 | Walk finished (one cycle) |
| ok | output | 1 | Translation succeeded |
| fault | output | 2 | 0 none, 1 not present, 2 reserved, 3 non-canonical |
| pa | output | PA_W | Physical address |
| page_size | output | 2 | 0 4 KB, 1 2 MB, 2 1 GB |
| attr_user | output | 1 | Combined user bit |
| attr_write | output | 1 | Combined writable bit |
| attr_nx | output | 1 | Combined no-execute bit |

## Verification
The bench sweeps virtual addresses from both canonical halves against each of the three leaf sizes. Checking the request addresses and the final address separates errors in index extraction from errors in offset merging.

Each table level in turn is made absent or reserved. A sixteen-way sweep of per-level user, write and no-execute patterns shows whether the attributes combine by AND, by OR, or not at all.

The bench's memory model forces compare-and-swap failures on a non-leaf and on a leaf entry. Counting the reads then tells a level retry apart from a full restart. Load and store pairs against clean and dirty leaves, and non-canonical addresses, cover the remaining paths.

// File: rtl/vmw_pkg.sv
package vmw_pkg;
   typedef enum logic [1:0] {
      FLT_NONE     = 2'd0,
      FLT_ABSENT   = 2'd1,
      FLT_RSVD     = 2'd2,
      FLT_NONCANON = 2'd3
   } flt_e;

   typedef enum logic [1:0] {
      PG_4K = 2'd0,
      PG_2M = 2'd1,
      PG_1G = 2'd2
   } pgsz_e;

   localparam int BIT_PRES  = 0;
   localparam int BIT_WR    = 1;
   localparam int BIT_USR   = 2;
   localparam int BIT_ACC   = 5;
   localparam int BIT_DIRTY = 6;
   localparam int BIT_BIG   = 7;
   localparam int BIT_XD    = 63;
endpackage

// File: rtl/vmw_entry_eval.sv
module vmw_entry_eval
   import vmw_pkg::*;
#(
   parameter int PA_W = 40
)(
   input  logic [63:0] entry,
   input  logic [1:0]  lvl,
   input  logic        nx_en,
   output logic        present,
   output logic        rsvd,
   output logic        leaf,
   output pgsz_e       size
);
   logic hi_rsvd;
   logic big;
   logic unused_eval;

   assign unused_eval = ^entry;
   assign big = entry[BIT_BIG];

   generate
      if (PA_W < 52) begin : g_hi
         assign hi_rsvd = |entry[51:PA_W];
      end else begin : g_nohi
         assign hi_rsvd = 1'b0;
      end
   endgenerate

   always_comb begin
      present = entry[BIT_PRES];
      leaf    = (lvl == 2'd3) || (big && (lvl == 2'd1 || lvl == 2'd2));
      size    = PG_4K;
      if (big && lvl == 2'd1) size = PG_1G;
      else if (big && lvl == 2'd2) size = PG_2M;
      rsvd = hi_rsvd || (!nx_en && entry[BIT_XD]) || (big && lvl == 2'd0);
      if (big && lvl == 2'd1) rsvd = rsvd || (|entry[29:13]);
      if (big && lvl == 2'd2) rsvd = rsvd || (|entry[20:13]);
   end
endmodule

// File: rtl/vmw_memreq.sv
module vmw_memreq #(
   parameter int PA_W = 40
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [PA_W-1:0] ld_addr,
   input  logic            ld_cas,
   input  logic [31:0]     ld_cmp,
   input  logic [31:0]     ld_swap,
   input  logic            ready,
   output logic            valid,
   output logic [PA_W-1:0] addr,
   output logic            cas,
   output logic [31:0]     cmp,
   output logic [31:0]     swap
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         addr  <= '0;
         cas   <= 1'b0;
         cmp   <= '0;
         swap  <= '0;
      end else if (load) begin
         valid <= 1'b1;
         addr  <= ld_addr;
         cas   <= ld_cas;
         cmp   <= ld_cmp;
         swap  <= ld_swap;
      end else if (valid && ready) begin
         valid <= 1'b0;
      end
   end

   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !ready |=> valid && $stable(addr) && $stable(cas));
endmodule

// File: rtl/vmap_walker.sv
module vmap_walker
   import vmw_pkg::*;
#(
   parameter int PA_W = 40
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [63:0]     va,
   input  logic [63:0]     root,
   input  logic            is_store,
   input  logic            nx_en,
   output logic            req_valid,
   input  logic            req_ready,
   output logic [PA_W-1:0] req_addr,
   output logic            req_cas,
   output logic [31:0]     req_cmp,
   output logic [31:0]     req_swap,
   input  logic            rsp_valid,
   input  logic [63:0]     rsp_data,
   output logic            done,
   output logic            ok,
   output logic [1:0]      fault,
   output logic [PA_W-1:0] pa,
   output logic [1:0]      page_size,
   output logic            attr_user,
   output logic            attr_write,
   output logic            attr_nx
);
   localparam int FR_W = PA_W - 12;

   generate
      if (PA_W < 32 || PA_W > 52) begin : g_bad_pa
         initial $fatal(1, "vmap_walker: PA_W must lie in 32..52");
      end
   endgenerate

   typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WRD, S_WCAS} st_e;

   st_e          state_q;
   logic [1:0]   lvl_q;
   logic [FR_W-1:0] base_q, root_q;
   logic [63:0]  ent_q;
   logic [47:0]  va_q;
   logic         st_q, nx_q;
   logic         acc_u, acc_w, acc_xn;
   logic         done_q, ok_q, u_q, w_q, x_q;
   flt_e         fault_q;
   pgsz_e        size_q;
   logic [PA_W-1:0] pa_q;

   logic [63:0]  cur_ent;
   logic         e_pres, e_rsvd, e_leaf;
   pgsz_e        e_size;
   logic [31:0]  setbits;
   logic         need_cas, cas_ok, cas_go, advance, mr_load;
   logic [8:0]   idx;
   logic         n_u, n_w, n_xn;
   logic [PA_W-1:0] pa_n;
   logic         canon;
   logic         unused_top;

   assign unused_top = ^{root[63:PA_W], root[11:0]};
   assign canon = (&va[63:47]) || !(|va[63:47]);

   always_comb begin
      case (lvl_q)
         2'd0:    idx = va_q[47:39];
         2'd1:    idx = va_q[38:30];
         2'd2:    idx = va_q[29:21];
         default: idx = va_q[20:12];
      endcase
   end

   assign cur_ent = (state_q == S_WCAS) ? ent_q : rsp_data;

   vmw_entry_eval #(.PA_W(PA_W)) u_eval (
      .entry   (cur_ent),
      .lvl     (lvl_q),
      .nx_en   (nx_q),
      .present (e_pres),
      .rsvd    (e_rsvd),
      .leaf    (e_leaf),
      .size    (e_size)
   );

   always_comb begin
      setbits = 32'd1 << BIT_ACC;
      if (e_leaf && st_q) setbits = setbits | (32'd1 << BIT_DIRTY);
   end

   assign need_cas = |(setbits & ~cur_ent[31:0]);
   assign cas_ok   = (rsp_data[31:0] == ent_q[31:0]);
   assign cas_go   = (state_q == S_WRD) && rsp_valid && e_pres && !e_rsvd && need_cas;
   assign advance  = ((state_q == S_WRD) && rsp_valid && e_pres && !e_rsvd && !need_cas)
                  || ((state_q == S_WCAS) && rsp_valid && cas_ok);
   assign mr_load  = (state_q == S_ISSUE) || cas_go;

   assign n_u  = acc_u & cur_ent[BIT_USR];
   assign n_w  = acc_w & cur_ent[BIT_WR];
   assign n_xn = acc_xn & ~cur_ent[BIT_XD];

   always_comb begin
      case (e_size)
         PG_1G:   pa_n = {cur_ent[PA_W-1:30], va_q[29:0]};
         PG_2M:   pa_n = {cur_ent[PA_W-1:21], va_q[20:0]};
         default: pa_n = {cur_ent[PA_W-1:12], va_q[11:0]};
      endcase
   end

   vmw_memreq #(.PA_W(PA_W)) u_req (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (mr_load),
      .ld_addr ({base_q, idx, 3'b000}),
      .ld_cas  (state_q == S_WRD),
      .ld_cmp  (rsp_data[31:0]),
      .ld_swap (rsp_data[31:0] | setbits),
      .ready   (req_ready),
      .valid   (req_valid),
      .addr    (req_addr),
      .cas     (req_cas),
      .cmp     (req_cmp),
      .swap    (req_swap)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         lvl_q   <= '0;
         base_q  <= '0;
         root_q  <= '0;
         ent_q   <= '0;
         va_q    <= '0;
         st_q    <= 1'b0;
         nx_q    <= 1'b0;
         acc_u   <= 1'b1;
         acc_w   <= 1'b1;
         acc_xn  <= 1'b1;
         done_q  <= 1'b0;
         ok_q    <= 1'b0;
         fault_q <= FLT_NONE;
         size_q  <= PG_4K;
         pa_q    <= '0;
         u_q     <= 1'b0;
         w_q     <= 1'b0;
         x_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            S_IDLE: if (start) begin
               va_q   <= va[47:0];
               root_q <= root[PA_W-1:12];
               base_q <= root[PA_W-1:12];
               st_q   <= is_store;
               nx_q   <= nx_en;
               lvl_q  <= '0;
               acc_u  <= 1'b1;
               acc_w  <= 1'b1;
               acc_xn <= 1'b1;
               if (!canon) begin
                  done_q  <= 1'b1;
                  ok_q    <= 1'b0;
                  fault_q <= FLT_NONCANON;
               end else begin
                  state_q <= S_ISSUE;
               end
            end
            S_ISSUE: state_q <= S_WRD;
            S_WRD: if (rsp_valid) begin
               ent_q <= rsp_data;
               if (!e_pres) begin
                  state_q <= S_IDLE;
                  done_q  <= 1'b1;
                  ok_q    <= 1'b0;
                  fault_q <= FLT_ABSENT;
               end else if (e_rsvd) begin
                  state_q <= S_IDLE;
                  done_q  <= 1'b1;
                  ok_q    <= 1'b0;
                  fault_q <= FLT_RSVD;
               end else if (need_cas) begin
                  state_q <= S_WCAS;
               end
            end
            S_WCAS: if (rsp_valid && !cas_ok) begin
               state_q <= S_ISSUE;
               if (e_leaf) begin
                  lvl_q  <= '0;
                  base_q <= root_q;
                  acc_u  <= 1'b1;
                  acc_w  <= 1'b1;
                  acc_xn <= 1'b1;
               end
            end
            default: state_q <= S_IDLE;
         endcase
         if (advance) begin
            if (e_leaf) begin
               state_q <= S_IDLE;
               done_q  <= 1'b1;
               ok_q    <= 1'b1;
               fault_q <= FLT_NONE;
               pa_q    <= pa_n;
               size_q  <= e_size;
               u_q     <= n_u;
               w_q     <= n_w & (st_q | cur_ent[BIT_DIRTY]);
               x_q     <= ~n_xn;
            end else begin
               state_q <= S_ISSUE;
               lvl_q   <= lvl_q + 2'd1;
               base_q  <= cur_ent[PA_W-1:12];
               acc_u   <= n_u;
               acc_w   <= n_w;
               acc_xn  <= n_xn;
            end
         end
      end
   end

   assign done       = done_q;
   assign ok         = ok_q;
   assign fault      = fault_q;
   assign pa         = pa_q;
   assign page_size  = size_q;
   assign attr_user  = u_q;
   assign attr_write = w_q;
   assign attr_nx    = x_q;

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R11
   idle_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !req_valid);
   // R6
   cas_sets_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_cas |-> ((req_cmp & ~req_swap) == 32'd0) && req_swap[BIT_ACC]);
   // R4
   pa_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && ok |-> pa[11:0] == va_q[11:0]);
   // R9
   clean_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && ok && !st_q && !ent_q[BIT_DIRTY] |-> !attr_write);
   // R8
   nx_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && ok && ent_q[BIT_XD] |-> attr_nx);
endmodule

// File: tb/vmap_walker_test.sv
module vmap_walker_test;
   localparam int PA_W = 40;
   localparam logic [63:0] ROOT = 64'h1ABC;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, start, is_store, nx_en;
   logic [63:0] va, root;
   logic req_valid, req_ready, req_cas;
   logic [PA_W-1:0] req_addr;
   logic [31:0] req_cmp, req_swap;
   logic rsp_valid;
   logic [63:0] rsp_data;
   logic done, ok, attr_user, attr_write, attr_nx;
   logic [1:0] fault, page_size;
   logic [PA_W-1:0] pa;

   vmap_walker #(.PA_W(PA_W)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .va(va), .root(root),
      .is_store(is_store), .nx_en(nx_en), .req_valid(req_valid),
      .req_ready(req_ready), .req_addr(req_addr), .req_cas(req_cas),
      .req_cmp(req_cmp), .req_swap(req_swap), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .done(done), .ok(ok), .fault(fault), .pa(pa),
      .page_size(page_size), .attr_user(attr_user), .attr_write(attr_write),
      .attr_nx(attr_nx)
   );

   int n_chk = 0, n_fail = 0;
   int n_rd, n_cas, steal;
   logic [63:0] rd_log [16];
   logic [63:0] mem [logic [63:0]];
   bit pend;
   logic [63:0] pdata;

   function automatic logic [63:0] rdm(input logic [63:0] a);
      return mem.exists(a) ? mem[a] : 64'h0;
   endfunction

   function automatic logic [63:0] tb_base(input int l);
      return 64'h1000 * (l + 1);
   endfunction

   function automatic logic [63:0] ea(input logic [63:0] v, input int l);
      return tb_base(l) + (((v >> (39 - 9 * l)) & 64'h1FF) << 3);
   endfunction

   function automatic logic [63:0] frame(input int leaf);
      if (leaf == 1) return 64'h12_4000_0000;
      if (leaf == 2) return 64'h12_3460_0000;
      return 64'h12_3456_7000;
   endfunction

   function automatic logic [63:0] exp_pa(input logic [63:0] v, input int leaf);
      logic [63:0] m;
      m = (leaf == 1) ? 64'h3FFF_FFFF : (leaf == 2) ? 64'h1F_FFFF : 64'hFFF;
      return frame(leaf) | (v & m);
   endfunction

   // memory responder: one request, response on the following cycle
   initial begin
      rsp_valid = 1'b0; rsp_data = '0; pend = 1'b0; req_ready = 1'b1;
      forever begin
         @(negedge clk);
         if (pend) begin
            rsp_valid = 1'b1; rsp_data = pdata; pend = 1'b0;
         end else begin
            rsp_valid = 1'b0;
            if (req_valid) begin
               logic [63:0] a, old;
               a = {{(64-PA_W){1'b0}}, req_addr};
               if (!req_cas) begin
                  if (n_rd < 16) rd_log[n_rd] = a;
                  n_rd++;
                  pdata = rdm(a);
               end else begin
                  n_cas++;
                  if (steal > 0) begin
                     mem[a] = rdm(a) ^ 64'h200;
                     steal--;
                  end
                  old = rdm(a);
                  if (old[31:0] == req_cmp) mem[a] = {old[63:32], req_swap};
                  pdata = old;
               end
               pend = 1'b1;
            end
         end
      end
   end

   task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   task automatic build(input logic [63:0] v, input int leaf, input logic [3:0][63:0] f);
      mem.delete();
      for (int l = 0; l <= leaf; l++) begin
         if (l < leaf) mem[ea(v, l)] = tb_base(l + 1) | f[l];
         else mem[ea(v, l)] = frame(leaf) | f[l] | ((leaf < 3) ? 64'h80 : 64'h0);
      end
   endtask

   task automatic walk(input logic [63:0] v, input bit s, input bit nx);
      int cyc;
      n_rd = 0; n_cas = 0;
      @(negedge clk);
      va = v; is_store = s; nx_en = nx; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (!done && cyc < 400) begin
         @(negedge clk);
         cyc++;
      end
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL R11 walk watchdog actual=%0d expected=done", cyc);
      end
   endtask

   localparam logic [63:0] PWU = 64'h7;

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL R11 global watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [63:0] v;
      rst_n = 1'b0; start = 1'b0; va = '0; root = ROOT; is_store = 1'b0;
      nx_en = 1'b0; steal = 0; n_rd = 0; n_cas = 0;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 reset done", done, 0);
      chk("R11 reset req_valid", req_valid, 0);
      rst_n = 1'b1;

      // R1 R6 R7: 4K store walk
      v = 64'h0000_7F12_3456_7ABC;
      build(v, 3, {4{PWU}});
      walk(v, 1, 0);
      chk("R4 4K ok", ok, 1);
      chk("R4 4K pa", pa, exp_pa(v, 3));
      chk("R4 4K size", page_size, 0);
      chk("R1 read count", n_rd, 4);
      for (int l = 0; l < 4; l++) chk("R1 entry address", rd_log[l], ea(v, l));
      for (int l = 0; l < 3; l++) chk("R6 accessed set", rdm(ea(v, l)) & 64'h60, 64'h20);
      chk("R7 leaf A and D", rdm(ea(v, 3)) & 64'h60, 64'h60);
      chk("R8 attrs", {attr_user, attr_write, attr_nx}, 3'b110);

      // R4 sweep of addresses and page sizes
      for (int k = 0; k < 8; k++) begin
         v = (k * 64'h0000_1357_9BDF_1235) & 64'h7FFF_FFFF_FFFF;
         if (k[0]) v = v | 64'hFFFF_8000_0000_0000;
         for (int lf = 1; lf <= 3; lf++) begin
            build(v, lf, {4{PWU}});
            walk(v, 1, 0);
            chk("R4 sweep ok", ok, 1);
            chk("R4 sweep pa", pa, exp_pa(v, lf));
            chk("R4 sweep size", page_size, (lf == 1) ? 2 : (lf == 2) ? 1 : 0);
         end
      end

      // R2 absent at each level
      v = 64'h0000_1234_5678_9000;
      for (int l = 0; l < 4; l++) begin
         logic [3:0][63:0] f;
         f = {4{PWU}};
         f[l] = 64'h6;
         build(v, 3, f);
         walk(v, 0, 0);
         chk("R2 absent fault", {ok, fault}, 3'b001);
         chk("R2 reads stop", n_rd, l + 1);
      end

      // R3 reserved bits
      build(v, 3, {PWU, PWU, PWU, PWU | 64'h80});
      walk(v, 0, 0);
      chk("R3 size bit at top", fault, 2);
      build(v, 3, {PWU, PWU | 64'h100_0000_0000, PWU, PWU});
      walk(v, 0, 0);
      chk("R3 address above PA_W", fault, 2);
      build(v, 3, {PWU | 64'h8000_0000_0000_0000, PWU, PWU, PWU});
      walk(v, 0, 0);
      chk("R3 nx while disabled", fault, 2);
      walk(v, 0, 1);
      chk("R8 nx enabled ok", ok, 1);
      chk("R8 nx set", attr_nx, 1);

      // R5 large page low frame bits
      build(v, 2, {PWU, PWU | 64'h2000, PWU, PWU});
      walk(v, 0, 0);
      chk("R5 2M bit13 reserved", fault, 2);
      build(v, 2, {PWU, PWU | 64'h1000, PWU, PWU});
      walk(v, 0, 0);
      chk("R5 2M bit12 allowed", ok, 1);
      chk("R5 2M pa", pa, exp_pa(v, 2));
      build(v, 1, {PWU, PWU, PWU | 64'h2000_0000, PWU});
      walk(v, 0, 0);
      chk("R5 1G bit29 reserved", fault, 2);

      // R8 attribute sweep
      for (int m = 0; m < 16; m++) begin
         logic [3:0][63:0] f;
         for (int l = 0; l < 4; l++)
            f[l] = m[l] ? (64'h5 | 64'h8000_0000_0000_0000) : 64'h3;
         build(v, 3, f);
         walk(v, 1, 1);
         chk("R8 user and", attr_user, (m == 15));
         chk("R8 write and", attr_write, (m == 0));
         chk("R8 nx or", attr_nx, (m != 0));
      end

      // R9 dirty handling
      build(v, 3, {4{PWU}});
      walk(v, 0, 0);
      chk("R9 clean load no write", attr_write, 0);
      chk("R7 load leaves D clear", rdm(ea(v, 3)) & 64'h60, 64'h20);
      build(v, 3, {PWU | 64'h40, PWU, PWU, PWU});
      walk(v, 0, 0);
      chk("R9 dirty load write", attr_write, 1);

      // R6 non-leaf contention: re-read one level
      build(v, 3, {4{PWU}});
      steal = 1;
      walk(v, 1, 0);
      chk("R6 retry ok", ok, 1);
      chk("R6 retry reads", n_rd, 5);
      // R7 leaf contention: restart walk
      build(v, 3, {PWU, PWU | 64'h20, PWU | 64'h20, PWU | 64'h20});
      steal = 1;
      walk(v, 1, 0);
      chk("R7 restart ok", ok, 1);
      chk("R7 restart reads", n_rd, 8);
      chk("R7 restart swaps", n_cas, 2);

      // R6 no swap when already accessed
      build(v, 3, {4{PWU | 64'h20}});
      walk(v, 0, 0);
      chk("R6 no swap needed", n_cas, 0);

      // R10 non-canonical
      walk(64'h0000_8000_0000_0000, 0, 0);
      chk("R10 fault", {ok, fault}, 3'b011);
      chk("R10 no request", n_rd + n_cas, 0);
      walk(64'hFFFF_0000_0000_0000, 1, 0);
      chk("R10 fault upper", fault, 3);

      // R11 results hold
      build(v, 3, {4{PWU}});
      walk(v, 1, 0);
      repeat (5) @(negedge clk);
      chk("R11 done pulse", done, 0);
      chk("R11 pa held", pa, exp_pa(v, 3));

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule